// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers the interrupt requests of a small byte-wide peripheral into one level interrupt line. It keeps seven pending-flag bits and seven enable bits. Single-cycle event pulses from two timers, a shift register and four port control lines set the flags. The interrupt line is raised while any flag is both pending and enabled.

A processor reaches the two registers through a byte port with a one-bit register select. Flags are cleared by writing ones to them, and the enable register is changed by a set-or-clear write whose top data bit picks the direction. The neighbouring registers of the peripheral can also clear single flags through side-effect clear strobes, for example when a timer counter is read.

Top module: `irq_flag_unit`

## Requirements
- R1: While `rst` is high on a clock edge, the flag register and the enable register are cleared to zero and `irq` goes low. After reset both registers read back as zero in bits 6..0.
- R2: `irq` is a registered output. After any clock edge it equals the OR of (flags AND enables) as they stood before that edge, so it follows a register change one cycle later.
- R3: With `reg_sel` = 0 (flag register), `rd_data[6:0]` holds the flags and `rd_data[7]` is 1 exactly when some flag is both set and enabled. The read has no side effect.
- R4: With `reg_sel` = 1 (enable register), `rd_data[6:0]` holds the enables and `rd_data[7]` is always 1.
- R5: A write (`wr_stb` = 1) to the enable register with `wr_data[7]` = 1 sets every enable bit whose data bit in 6..0 is 1 and leaves the others unchanged.
- R6: A write to the enable register with `wr_data[7]` = 0 clears every enable bit whose data bit in 6..0 is 1 and leaves the others unchanged.
- R7: A write to the flag register clears every flag whose data bit in 6..0 is 1. Data bits that are 0, and data bit 7, change nothing.
- R8: A one on `evt_set[i]` sets flag i on the next edge. The bit positions are: timer 1 = bit 6, timer 2 = bit 5, shift register = bit 2, port control lines = bits 4, 3, 1 and 0.
- R9: A one on `evt_clr[i]` clears flag i on the next edge.
- R10: When a set event and a clear for the same flag arrive in the same cycle, the flag ends up set. The clear may be a side strobe or a flag-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 = flags, 1 = enables |
| wr_stb | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| evt_set | input | 7 | Per-flag set pulses |
| evt_clr | input | 7 | Per-flag side-effect clear strobes |
| irq | output | 1 | Level interrupt output |

## Verification
The hardest case to reach from the ports is a cycle in which one flag is set and cleared at the same time. The stimulus drives an event pulse together with a side clear strobe on the same bit, and in another cycle together with a flag-register write that has that bit's data bit at 1. The cycle after each, the flag is read back to confirm it is set. The one-cycle lag of `irq` is checked on every cycle: a reference model predicts the line from the register state that stood before each edge, so every rise and every fall is compared in the exact cycle it should occur.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_SRC = DATA_W - 1;
    localparam int TOP_BIT = DATA_W - 1;

    localparam int BIT_TMR1  = 6;
    localparam int BIT_TMR2  = 5;
    localparam int BIT_SHIFT = 2;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [DATA_W-1:0]  byte_t;

    typedef enum logic {
        SEL_FLAGS   = 1'b0,
        SEL_ENABLES = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     hit_flags;
        logic     hit_enables;
        logic     dir_set;
        src_vec_t mask;
    } wr_req_t;

    function automatic wr_req_t decode_write(input logic stb, input reg_sel_e sel,
                                             input byte_t data);
        wr_req_t r;
        r.hit_flags   = stb && (sel == SEL_FLAGS);
        r.hit_enables = stb && (sel == SEL_ENABLES);
        r.dir_set     = data[TOP_BIT];
        r.mask        = data[NUM_SRC-1:0];
        return r;
    endfunction

endpackage

// File: rtl/irqfe_flag_bank.sv
module irqfe_flag_bank
    import irqfe_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic         wr_clr,
    input  logic [N-1:0] wr_mask,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr_any;
        assign clr_any = clr_vec[i] || (wr_clr && wr_mask[i]);

        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_any)    flags[i] <= 1'b0;
        end

        assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> flags[i]);

        assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_vec[i]) |=> !flags[i]);

        assert_write_clear_R7: assert property (@(posedge clk) disable iff (rst)
            (wr_clr && wr_mask[i] && !set_vec[i]) |=> !flags[i]);

        assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (!set_vec[i] && !clr_vec[i] && !(wr_clr && wr_mask[i])) |=> $stable(flags[i]));
    end

    assert_reset_flags_R1: assert property (@(posedge clk) rst |=> (flags == '0));

endmodule

// File: rtl/irqfe_enable_bank.sv
module irqfe_enable_bank
    import irqfe_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         dir_set,
    input  logic [N-1:0] mask,
    output logic [N-1:0] enables
);

    logic [N-1:0] en_next;

    always_comb begin
        en_next = enables;
        if (wr) begin
            if (dir_set) en_next = enables | mask;
            else         en_next = enables & ~mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) enables <= '0;
        else     enables <= en_next;
    end

    assert_en_set_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && dir_set) |=> ((enables & $past(mask)) == $past(mask)));

    assert_en_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && !dir_set) |=> ((enables & $past(mask)) == '0));

    assert_en_keep_R5: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((enables & ~$past(mask)) == ($past(enables) & ~$past(mask))));

    assert_reset_en_R1: assert property (@(posedge clk) rst |=> (enables == '0));

endmodule

// File: rtl/irqfe_irq_out.sv
module irqfe_irq_out
    import irqfe_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         pending,
    output logic         irq
);

    assign pending = |(flags & enables);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= pending;
    end

    assert_irq_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(pending));

    assert_irq_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> !$past(pending));

    assert_irq_reset_R1: assert property (@(posedge clk) rst |=> !irq);

endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irqfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_sel,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic [6:0] evt_set,
    input  logic [6:0] evt_clr,
    output logic       irq
);

    reg_sel_e sel;
    wr_req_t  req;
    src_vec_t flags;
    src_vec_t enables;
    logic     pending;

    assign sel = reg_sel_e'(reg_sel);
    assign req = decode_write(wr_stb, sel, wr_data);

    irqfe_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (evt_set),
        .clr_vec (evt_clr),
        .wr_clr  (req.hit_flags),
        .wr_mask (req.mask),
        .flags   (flags)
    );

    irqfe_enable_bank #(.N(NUM_SRC)) u_enables (
        .clk     (clk),
        .rst     (rst),
        .wr      (req.hit_enables),
        .dir_set (req.dir_set),
        .mask    (req.mask),
        .enables (enables)
    );

    irqfe_irq_out #(.N(NUM_SRC)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .enables (enables),
        .pending (pending),
        .irq     (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_FLAGS:   rd_data = {pending, flags};
            SEL_ENABLES: rd_data = {1'b1, enables};
            default:     rd_data = '0;
        endcase
    end

    assert_en_read_top_R4: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> rd_data[7]);

    assert_summary_R3: assert property (@(posedge clk) disable iff (rst)
        (!reg_sel && rd_data[7]) |=> irq);

endmodule

// File: tb/irq_flag_unit_tb.sv
module irq_flag_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [6:0] evt_set = '0;
    logic [6:0] evt_clr = '0;
    logic       irq;

    always #2 clk = ~clk;

    irq_flag_unit u_dut (
        .clk     (clk),
        .rst     (rst),
        .reg_sel (reg_sel),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .evt_set (evt_set),
        .evt_clr (evt_clr),
        .irq     (irq)
    );

    typedef struct {
        logic [7:0] exp_rd;
        logic       exp_irq;
        string      tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [6:0] m_flags = '0;
    logic [6:0] m_en = '0;
    logic       m_irq = 1'b0;

    // Monitor: compares one expected item per cycle, 1 ns after the driver's negedge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (rd_data !== it.exp_rd) begin
                    bad++;
                    $display("FAIL %s rd_data actual=%02h expected=%02h", it.tag, rd_data, it.exp_rd);
                end
                total++;
                if (irq !== it.exp_irq) begin
                    bad++;
                    $display("FAIL %s irq actual=%0b expected=%0b", it.tag, irq, it.exp_irq);
                end
            end
        end
    end

    // Driver: applies one cycle of stimulus, pushes expectations, advances the model.
    task automatic step(input logic sel, input logic wr, input logic [7:0] wd,
                        input logic [6:0] st, input logic [6:0] cl, input string tag);
        item_t it;
        logic [6:0] clr_mask;
        reg_sel = sel;
        wr_stb  = wr;
        wr_data = wd;
        evt_set = st;
        evt_clr = cl;
        it.exp_rd  = sel ? {1'b1, m_en} : {|(m_flags & m_en), m_flags};
        it.exp_irq = m_irq;
        it.tag     = tag;
        q.push_back(it);
        m_irq = |(m_flags & m_en);
        clr_mask = cl | ((wr && !sel) ? wd[6:0] : 7'h00);
        m_flags = (m_flags & ~clr_mask) | st;
        if (wr && sel) m_en = wd[7] ? (m_en | wd[6:0]) : (m_en & ~wd[6:0]);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(0, 0, 8'h00, 7'h00, 7'h00, "R1 flags after reset");
        step(1, 0, 8'h00, 7'h00, 7'h00, "R1 enables after reset");
        step(0, 0, 8'h00, 7'h40, 7'h00, "R8 timer1 event bit6");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R3 flag read, not enabled");
        step(1, 1, 8'hC0, 7'h00, 7'h00, "R5 enable set bit6");
        step(1, 0, 8'h00, 7'h00, 7'h00, "R4 enable read top bit");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R2 irq rises one cycle late");
        step(0, 0, 8'h00, 7'h24, 7'h00, "R8 timer2 bit5 and shift bit2");
        step(1, 1, 8'hA4, 7'h00, 7'h00, "R5 enable set bits5,2");
        step(1, 0, 8'h00, 7'h00, 7'h00, "R5 enable readback");
        step(0, 1, 8'h20, 7'h00, 7'h00, "R7 write-clear bit5");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R7 others kept");
        step(0, 0, 8'h00, 7'h00, 7'h40, "R9 side clear bit6");
        step(0, 0, 8'h00, 7'h04, 7'h04, "R10 set vs side clear bit2");
        step(0, 1, 8'h20, 7'h20, 7'h00, "R10 set vs write clear bit5");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R10 flags stay set");
        step(1, 1, 8'h24, 7'h00, 7'h00, "R6 enable clear bits5,2");
        step(1, 0, 8'h00, 7'h00, 7'h00, "R6 enable readback");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R2 irq falls one cycle late");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R3 summary low");
        step(0, 1, 8'h80, 7'h00, 7'h00, "R7 data bit7 only");
        step(0, 0, 8'h00, 7'h1B, 7'h00, "R8 port line bits");
        step(1, 1, 8'hFF, 7'h00, 7'h00, "R5 enable all");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R3 summary high");
        step(0, 1, 8'h7F, 7'h00, 7'h00, "R7 clear all flags");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R2 irq after clear-all");
        step(1, 1, 8'h00, 7'h00, 7'h00, "R6 zero mask no change");
        step(1, 0, 8'h00, 7'h00, 7'h00, "R6 readback");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R2 settle");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_flags = '0; m_en = '0; m_irq = 1'b0;
        step(1, 0, 8'h00, 7'h00, 7'h00, "R1 enables after second reset");
        step(0, 0, 8'h00, 7'h00, 7'h00, "R1 flags after second reset");
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule